// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a watchdog that asks for a system reset when software stops servicing it. Software controls it through one control word on a 32-bit register bus. The same word carries three things: a down-count value, a start/stop command and a 7-bit key. A separate status offset returns the live count. The countdown advances only on a slow tick-enable input. That input comes from elsewhere in the chip; the intended rate is roughly 760 Hz.

While the watchdog is stopped, any control write is taken. Once a write has started it, the block accepts the next control write only if that write's key is the bitwise inverse of the key stored last. A write that fails this test is dropped without any trace: the stored word, the count and the running state all stay as they were. An accepted write reloads the counter and either starts it or stops it. If the count runs out, the block raises a reset request for one clock cycle, and the counter stays idle until software writes the control word again.

Top module: `wdk_top`

## Requirements
- R1: After reset, `rst_req` is 0, the control offset (0x40) reads 0 and the status offset (0x44) reads 0. The watchdog is therefore disabled and stopped.
- R2: The watchdog is enabled when bit 8 of the stored control word is 1. While it is disabled, every write to offset 0x40 is accepted. The whole 32-bit written value becomes the stored control word, which offset 0x40 reads back.
- R3: While the watchdog is enabled, a write to 0x40 is discarded if its bits [15:9] are not the bitwise inverse of bits [15:9] of the stored word. After such a write the stored word, the count and the running state are unchanged.
- R4: While the watchdog is enabled, a write to 0x40 is accepted if its bits [15:9] equal the inverse of the stored key. Its value becomes the new stored word, so its key is the reference for the next write.
- R5: An accepted write loads the counter from bits [7:0] of the written value. A value of 0 loads 256.
- R6: An accepted write with bit 8 set starts the countdown. With bit 8 clear, the counter is still loaded but it is stopped, and ticks leave it unchanged.
- R7: While the counter is running, each clock cycle with `tick` high lowers the count by one. Without a tick, or while the counter is stopped, the count holds.
- R8: When a tick arrives with a count of 1, the count becomes 0 and `rst_req` is high for exactly the next clock cycle. The counter then stops at 0, and further ticks raise no new request.
- R9: A read of offset 0x44 returns the count zero-extended to 32 bits. A read of any offset other than 0x40 or 0x44, and any cycle without `rd_en`, returns 0.
- R10: If an accepted write and a tick fall in the same cycle, the write wins. The count takes the written value and the tick is lost.
- R11: Writes to any offset other than 0x40 change neither the stored word nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` and `rd_en` |
| tick | input | 1 | Slow count-enable pulse |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench first kicks with the same key twice, to show that the second write is lost: a design that compared keys directly would reload there. It then writes a count of 0, where a design that forgot the 256 substitution would expire at once. It lands a kick on the same cycle as a tick, where a design with the wrong priority would show a count one lower than written. Last, it lets the count run out and keeps ticking afterwards, to catch a design whose request lasts more than one cycle, or that wraps from 0 to 255 and fires again.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // Register offsets within the block's window
    localparam logic [7:0] CTRL_OFS = 8'h40;
    localparam logic [7:0] STAT_OFS = 8'h44;

    // What the counter does in a given cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/wdk_decode.sv
module wdk_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ctrl,
    output logic              rd_ctrl,
    output logic              rd_stat
);
    import wdk_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    always_comb begin
        wr_ctrl = wr_en && (addr == CTRL_A);
        rd_ctrl = rd_en && (addr == CTRL_A);
        rd_stat = rd_en && (addr == STAT_A);
    end
endmodule

// File: rtl/wdk_key_gate.sv
module wdk_key_gate #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int EN_BIT  = CNT_W;
    localparam int KEY_LSB = CNT_W + 1;
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } gate_t;

    gate_t st_d, st_q;
    logic  armed;
    logic  key_ok;

    always_comb begin
        st_d   = st_q;
        armed  = st_q.word[EN_BIT];
        key_ok = (wdata[KEY_MSB:KEY_LSB] == ~st_q.word[KEY_MSB:KEY_LSB]);
        accept = wr_ctrl && (!armed || key_ok);
        if (accept) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word = st_q.word;
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_run,
    input  logic             tick,
    output logic [CNT_W:0]   count,
    output logic             expire
);
    import wdk_pkg::*;

    localparam int          CW   = CNT_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << CNT_W;
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          req;
    } ctr_t;

    ctr_t    st_d, st_q;
    cnt_op_e op;

    always_comb begin
        if (load) begin
            op = CNT_LOAD;
        end else if (tick && st_q.run) begin
            op = CNT_STEP;
        end else begin
            op = CNT_HOLD;
        end

        st_d     = st_q;
        st_d.req = 1'b0;
        unique case (op)
            CNT_LOAD: begin
                st_d.cnt = (load_val == '0) ? FULL : {1'b0, load_val};
                st_d.run = load_run;
            end
            CNT_STEP: begin
                st_d.cnt = st_q.cnt - ONE;
                if (st_q.cnt == ONE) begin
                    st_d.run = 1'b0;
                    st_d.req = 1'b1;
                end
            end
            default: begin
                st_d.cnt = st_q.cnt;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign expire = st_q.req;
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic              rst_req
);
    localparam int CW = CNT_W + 1;

    logic              wr_ctrl, rd_ctrl, rd_stat;
    logic              accept;
    logic [DATA_W-1:0] ctrl_w;
    logic [CW-1:0]     cnt_w;

    wdk_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_ctrl (wr_ctrl),
        .rd_ctrl (rd_ctrl),
        .rd_stat (rd_stat)
    );

    wdk_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .accept    (accept),
        .ctrl_word (ctrl_w)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wdata[CNT_W-1:0]),
        .load_run (wdata[CNT_W]),
        .tick     (tick),
        .count    (cnt_w),
        .expire   (rst_req)
    );

    always_comb begin
        rdata = '0;
        if (rd_ctrl) begin
            rdata = ctrl_w;
        end else if (rd_stat) begin
            rdata = DATA_W'(cnt_w);
        end
    end
endmodule

// File: rtl/wdk_check.sv
module wdk_check #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tick,
    input logic              rst_req,
    input logic [CNT_W:0]    cnt,
    input logic [DATA_W-1:0] ctrl
);
    localparam int KL = CNT_W + 1;
    localparam int KM = KL + KEY_W - 1;
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(wdk_pkg::CTRL_OFS);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == CA);

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r8_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));

    a_r3_wrong_key: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl[CNT_W] && (wdata[KM:KL] != ~ctrl[KM:KL]))
        |=> ($stable(ctrl) && $stable(cnt)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(cnt));

    a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl[CNT_W] && (wdata[CNT_W-1:0] == '0)) |=> (cnt == FULL));

    a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != CA)) |=> $stable(ctrl));
endmodule

bind wdk_top wdk_check #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tick    (tick),
    .rst_req (rst_req),
    .cnt     (cnt_w),
    .ctrl    (ctrl_w)
);

// File: tb/test_wdk_top.sv
module test_wdk_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0, tick = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [31:0] m_ctrl = '0;
    int          m_cnt = 0;
    bit          m_run = 0;
    bit          m_req = 0;

    always #4 clk = ~clk;

    wdk_top i_wdk_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick), .rst_req(rst_req)
    );

    function automatic logic [31:0] kword(int key, int cmd, int cnt);
        return 32'((key & 'h7f) << 9) | 32'((cmd & 1) << 8) | 32'(cnt & 'hff);
    endfunction

    function automatic logic [31:0] m_read();
        if (!rd_en) return 32'h0;
        if (addr == 8'h40) return m_ctrl;
        if (addr == 8'h44) return 32'(m_cnt);
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // reference model: updated on every edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = 0; m_run = 0; m_req = 0;
        end else begin
            bit acc;
            acc = wr_en && addr == 8'h40 &&
                  (!m_ctrl[8] || wdata[15:9] == ~m_ctrl[15:9]);
            m_req = 0;
            if (acc) begin
                m_ctrl = wdata;
                m_cnt  = (wdata[7:0] == 0) ? 256 : int'(wdata[7:0]);
                m_run  = wdata[8];
            end else if (tick && m_run) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_run = 0;
                    m_req = 1;
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 rst_req", 32'(rst_req), 32'(m_req));
            check("R9 rdata", rdata, m_read());
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk); #1;
            wr_en = 0; rd_en = 0; tick = 0;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, bit t);
        @(negedge clk); #1;
        wr_en = 1; rd_en = 0; addr = a; wdata = d; tick = t;
        @(negedge clk); #1;
        wr_en = 0; tick = 0;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk); #1;
            wr_en = 0; rd_en = 0; tick = 1;
        end
        @(negedge clk); #1;
        tick = 0;
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        @(negedge clk); #1;
        wr_en = 0; tick = 0; rd_en = 1; addr = a;
        #2;
        check(tag, rdata, exp);
        @(negedge clk); #1;
        rd_en = 0;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1;

        // R1 reset state
        check("R1 rst_req", 32'(rst_req), 32'h0);
        rd("R1 ctrl", 8'h40, 32'h0);
        rd("R1 stat", 8'h44, 32'h0);

        // R2 disabled: any write taken, full word stored
        wr(8'h40, 32'hABCD_0000 | kword('h15, 1, 5), 0);
        rd("R2 ctrl readback", 8'h40, 32'hABCD_0000 | kword('h15, 1, 5));
        rd("R5 load count", 8'h44, 32'd5);

        // R7 decrement on ticks, hold without
        ticks(2);
        rd("R7 after two ticks", 8'h44, 32'd3);
        idle(4);
        rd("R7 hold without tick", 8'h44, 32'd3);

        // R3 wrong key dropped
        wr(8'h40, kword('h15, 1, 100), 0);
        rd("R3 ctrl unchanged", 8'h40, 32'hABCD_0000 | kword('h15, 1, 5));
        rd("R3 count unchanged", 8'h44, 32'd3);

        // R4 matching key accepted
        wr(8'h40, kword('h6A, 1, 10), 0);
        rd("R4 ctrl new", 8'h40, kword('h6A, 1, 10));
        rd("R4 reload", 8'h44, 32'd10);

        // R11 other offset write ignored
        wr(8'h48, kword('h15, 0, 7), 0);
        rd("R11 ctrl", 8'h40, kword('h6A, 1, 10));
        rd("R11 count", 8'h44, 32'd10);

        // R6 stop with correct key, ticks ignored
        wr(8'h40, kword('h15, 0, 20), 0);
        ticks(3);
        rd("R6 stopped count", 8'h44, 32'd20);

        // R5 disabled again: zero count means 256
        wr(8'h40, kword('h33, 1, 0), 0);
        rd("R5 zero is 256", 8'h44, 32'd256);
        ticks(1);
        rd("R7 256 steps", 8'h44, 32'd255);

        // R10 write beats simultaneous tick
        wr(8'h40, kword('h4C, 1, 3), 1);
        rd("R10 write wins", 8'h44, 32'd3);

        // R8 expiry: single pulse, stays at 0
        ticks(2);
        @(negedge clk); #1; tick = 1;
        @(negedge clk);
        check("R8 pulse", 32'(rst_req), 32'h1);
        #1; tick = 1;
        @(negedge clk);
        check("R8 pulse ends", 32'(rst_req), 32'h0);
        #1; tick = 0;
        ticks(5);
        rd("R8 parked at zero", 8'h44, 32'd0);
        check("R8 no new request", 32'(rst_req), 32'h0);

        // R9 unmapped read
        rd("R9 unmapped", 8'h50, 32'h0);

        // R1 reset mid-operation
        wr(8'h40, kword('h33, 1, 9), 0);
        @(negedge clk); #1; rst_n = 0;
        idle(2);
        @(negedge clk); #1; rst_n = 1;
        rd("R1 ctrl after reset", 8'h40, 32'h0);
        rd("R1 stat after reset", 8'h44, 32'h0);
        wr(8'h40, kword('h01, 1, 4), 0);
        rd("R2 accept after reset", 8'h44, 32'd4);

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule